// File: doc/BRIEF.md
# Display Mode Selection Sequencer

This block runs once after every reset and settles which display resolution the frame buffer should start in. It draws on three sources, each with a higher rank than the one before it. The first source is a monitor sense code, which gives a starting mode. The second is the list of standard timing entries from the monitor identification image, which is fetched through an external byte reader. The third is a nonvolatile override setting, which wins over both.

After reset the sequencer turns the sense code into an initial mode and presents it right away. It then waits for sync output to be enabled and lets a fixed settling delay run out, counted from the system clock. Next it fires the byte reader and scans the standard timing window of the returned image for the first entry that the frame buffer supports. Last, it applies the override if one is valid and reports the result with a single done strobe.

Top module: `mode_select_seq`

## Requirements
- R1: While reset is held, `mode_out` is 4 (1152x900 at 66 Hz), and `done` and `rd_start` are low.
- R2: One clock after reset is released, `mode_out` shows the sense-derived mode. A sense code of 0 means no code is present and gives mode 4. A nonzero code s gives mode s, zero-extended.
- R3: `rd_start` is a one-cycle pulse. It never comes before `sync_en` is seen high. It comes DELAY_MS*CLK_HZ/1000 clock cycles (1.5 s by default) after the cycle in which `sync_en` was first sampled high.
- R4: The image bytes are counted from 0, one per `rd_valid` cycle after `rd_start`. Eight two-byte standard timing entries sit at byte offsets 38..53. The first byte of an entry gives horizontal pixels as (byte+31)*8. The second byte gives the aspect in bits [7:6] (01 = 4:3, 10 = 5:4) and the refresh rate in Hz as bits [5:0] + 60.
- R5: The supported table maps to mode codes as follows: 640 4:3 60 -> 0, 800 4:3 75 -> 1, 1024 4:3 60 -> 2, 1024 4:3 75 -> 3, 1152 4:3 66 -> 4, 1152 4:3 76 -> 5, 1280 5:4 60 -> 6, 1280 5:4 75 -> 7.
- R6: When several entries are supported, the one earliest in stored order is selected.
- R7: An entry of 01 01 is unused and is skipped. Entries that are not supported are also skipped.
- R8: If no entry is supported, or the reader answers with `rd_nodata`, the final mode is the sense-derived mode.
- R9: When `ovr_valid` is high at the resolve step, the final mode is `ovr_mode`. This holds whatever the image or the sense code gave.
- R10: `done` pulses for exactly one cycle per reset, and `mode_out` carries the final mode in that cycle. After that, `mode_out` holds, and reader responses and override changes have no effect until the next reset.
- R11: Bytes outside offsets 38..53 never take part in selection, even when they hold supported entry patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_code | input | SENSE_W | Monitor sense code, 0 means none |
| sync_en | input | 1 | Sync output enabled; starts the settling delay |
| rd_start | output | 1 | One-cycle pulse that launches the image reader |
| rd_valid | input | 1 | Reader byte strobe |
| rd_data | input | 8 | Reader byte |
| rd_nodata | input | 1 | Reader reports that no image is available |
| ovr_valid | input | 1 | Nonvolatile override is set |
| ovr_mode | input | 4 | Override mode code |
| mode_out | output | 4 | Current selected mode code |
| done | output | 1 | One-cycle strobe when the final mode is valid |

## Verification
The bench puts a supported entry ahead of a second one, and places it behind both an unused 01 01 pair and an unsupported entry. A sequencer that kept the last match, or that took the unused pair as a real entry, would report the wrong mode. Other cases put supported patterns just outside the window, place the only valid entry in the last slot, and feed bytes with idle gaps between strobes. These catch an off-by-one window and counting on the clock instead of on strobes. The bench also times the reader launch from the sync edge, so a delay that is too short or too long is caught. It applies the override both with and without image data, and sends reader traffic after done to expose a sequencer that changes its answer or strobes a second time.

// File: rtl/ms_pkg.sv
package ms_pkg;

  localparam int MODE_W  = 4;
  localparam int N_MODES = 8;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t MODE_DEFAULT = 4'd4;   // 1152x900 at 66 Hz

  localparam logic [1:0] ASP_4_3 = 2'b01;
  localparam logic [1:0] ASP_5_4 = 2'b10;

  typedef enum logic [2:0] {
    ST_SENSE,
    ST_WAIT_SYNC,
    ST_DELAY,
    ST_READ,
    ST_RESOLVE,
    ST_HOLD
  } seq_state_t;

  typedef struct packed {
    logic [11:0] hpix;
    logic [1:0]  aspect;
    logic [7:0]  hz;
    mode_t       code;
  } mode_entry_t;

  // Resolutions the frame buffer can drive, with their mode codes
  function automatic mode_entry_t supported_entry(input int idx);
    mode_entry_t e;
    case (idx)
      0:       e = '{hpix: 12'd640,  aspect: ASP_4_3, hz: 8'd60, code: 4'd0};
      1:       e = '{hpix: 12'd800,  aspect: ASP_4_3, hz: 8'd75, code: 4'd1};
      2:       e = '{hpix: 12'd1024, aspect: ASP_4_3, hz: 8'd60, code: 4'd2};
      3:       e = '{hpix: 12'd1024, aspect: ASP_4_3, hz: 8'd75, code: 4'd3};
      4:       e = '{hpix: 12'd1152, aspect: ASP_4_3, hz: 8'd66, code: 4'd4};
      5:       e = '{hpix: 12'd1152, aspect: ASP_4_3, hz: 8'd76, code: 4'd5};
      6:       e = '{hpix: 12'd1280, aspect: ASP_5_4, hz: 8'd60, code: 4'd6};
      default: e = '{hpix: 12'd1280, aspect: ASP_5_4, hz: 8'd75, code: 4'd7};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/ms_delay_timer.sv
module ms_delay_timer #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int DELAY_MS = 1500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int TICKS_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int PRE_W        = $clog2(TICKS_PER_MS + 1);
  localparam int MS_W         = $clog2(DELAY_MS + 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [MS_W-1:0]  ms_cnt;
  logic             pre_wrap;
  logic             ms_last;

  assign pre_wrap = (pre_cnt == PRE_W'(TICKS_PER_MS - 1));
  assign ms_last  = (ms_cnt == MS_W'(DELAY_MS - 1));
  assign expired  = run && pre_wrap && ms_last;

  // Prescaler to millisecond ticks, then millisecond count; both held at
  // zero whenever the delay is not running.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt <= '0;
      ms_cnt  <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      if (!ms_last) ms_cnt <= ms_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ms_mode_lookup.sv
module ms_mode_lookup
  import ms_pkg::*;
(
  input  logic [7:0] hsize_byte,
  input  logic [7:0] detail_byte,
  output logic       hit,
  output mode_t      code
);

  logic [11:0] hpix;
  logic [1:0]  aspect;
  logic [7:0]  hz;

  assign hpix   = ({4'd0, hsize_byte} + 12'd31) << 3;
  assign aspect = detail_byte[7:6];
  assign hz     = {2'b00, detail_byte[5:0]} + 8'd60;

  // Scan downwards so the lowest table slot wins on any overlap
  always_comb begin
    mode_entry_t e;
    hit  = 1'b0;
    code = '0;
    for (int i = N_MODES - 1; i >= 0; i--) begin
      e = supported_entry(i);
      if (e.hpix == hpix && e.aspect == aspect && e.hz == hz) begin
        hit  = 1'b1;
        code = e.code;
      end
    end
  end

endmodule

// File: rtl/ms_std_scan.sv
module ms_std_scan
  import ms_pkg::*;
#(
  parameter int IMG_BYTES   = 128,
  parameter int STD_BASE    = 38,
  parameter int STD_ENTRIES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       found,
  output mode_t      found_mode,
  output logic       window_done
);

  localparam int IDX_W    = $clog2(IMG_BYTES + 1);
  localparam int STD_LAST = STD_BASE + 2 * STD_ENTRIES - 1;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rel;
  logic [7:0]       hold_byte;
  logic             in_window;
  logic             second_half;
  logic             unused_pair;
  logic             lk_hit;
  mode_t            lk_code;

  assign rel         = idx - IDX_W'(STD_BASE);
  assign in_window   = (idx >= IDX_W'(STD_BASE)) && (idx <= IDX_W'(STD_LAST));
  assign second_half = rel[0];
  assign unused_pair = (hold_byte == 8'h01) && (byte_data == 8'h01);

  ms_mode_lookup u_lookup (
    .hsize_byte  (hold_byte),
    .detail_byte (byte_data),
    .hit         (lk_hit),
    .code        (lk_code)
  );

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx         <= '0;
      hold_byte   <= '0;
      found       <= 1'b0;
      found_mode  <= '0;
      window_done <= 1'b0;
    end else if (byte_valid) begin
      if (idx != IDX_W'(IMG_BYTES)) idx <= idx + 1'b1;
      if (in_window) begin
        if (!second_half) begin
          hold_byte <= byte_data;
        end else begin
          if (!found && lk_hit && !unused_pair) begin
            found      <= 1'b1;
            found_mode <= lk_code;
          end
          if (idx == IDX_W'(STD_LAST)) window_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mode_select_seq.sv
module mode_select_seq
  import ms_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int DELAY_MS    = 1500,
  parameter int SENSE_W     = 3,
  parameter int IMG_BYTES   = 128,
  parameter int STD_BASE    = 38,
  parameter int STD_ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SENSE_W-1:0] sense_code,
  input  logic               sync_en,
  output logic               rd_start,
  input  logic               rd_valid,
  input  logic [7:0]         rd_data,
  input  logic               rd_nodata,
  input  logic               ovr_valid,
  input  logic [3:0]         ovr_mode,
  output logic [3:0]         mode_out,
  output logic               done
);

  seq_state_t state;
  mode_t      sense_ext;
  mode_t      sense_mode;
  logic       nodata_seen;
  logic       delay_expired;
  logic       scan_found;
  mode_t      scan_mode;
  logic       scan_done;

  // Sense code width adapter
  generate
    if (SENSE_W >= MODE_W) begin : g_sense_trim
      assign sense_ext = sense_code[MODE_W-1:0];
    end else begin : g_sense_pad
      assign sense_ext = {{(MODE_W - SENSE_W){1'b0}}, sense_code};
    end
  endgenerate

  ms_delay_timer #(
    .CLK_HZ   (CLK_HZ),
    .DELAY_MS (DELAY_MS)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_DELAY),
    .expired (delay_expired)
  );

  ms_std_scan #(
    .IMG_BYTES   (IMG_BYTES),
    .STD_BASE    (STD_BASE),
    .STD_ENTRIES (STD_ENTRIES)
  ) u_scan (
    .clk         (clk),
    .rst         (rst),
    .clear       (state != ST_READ),
    .byte_valid  (rd_valid && state == ST_READ && !rd_nodata),
    .byte_data   (rd_data),
    .found       (scan_found),
    .found_mode  (scan_mode),
    .window_done (scan_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_SENSE;
      sense_mode  <= MODE_DEFAULT;
      mode_out    <= MODE_DEFAULT;
      nodata_seen <= 1'b0;
      rd_start    <= 1'b0;
      done        <= 1'b0;
    end else begin
      rd_start <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        ST_SENSE: begin
          sense_mode <= (sense_ext == '0) ? MODE_DEFAULT : sense_ext;
          mode_out   <= (sense_ext == '0) ? MODE_DEFAULT : sense_ext;
          state      <= ST_WAIT_SYNC;
        end
        ST_WAIT_SYNC: begin
          if (sync_en) state <= ST_DELAY;
        end
        ST_DELAY: begin
          if (delay_expired) begin
            rd_start <= 1'b1;
            state    <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_nodata) begin
            nodata_seen <= 1'b1;
            state       <= ST_RESOLVE;
          end else if (scan_done) begin
            state <= ST_RESOLVE;
          end
        end
        ST_RESOLVE: begin
          if (ovr_valid)                       mode_out <= ovr_mode;
          else if (scan_found && !nodata_seen) mode_out <= scan_mode;
          else                                 mode_out <= sense_mode;
          done  <= 1'b1;
          state <= ST_HOLD;
        end
        default: begin
          state <= ST_HOLD;
        end
      endcase
    end
  end

endmodule

// File: rtl/ms_seq_checker.sv
module ms_seq_checker #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int DELAY_MS = 1500
) (
  input logic       clk,
  input logic       rst,
  input logic       sync_en,
  input logic       rd_start,
  input logic       done,
  input logic [3:0] mode_out,
  input logic       ovr_valid,
  input logic [3:0] ovr_mode
);

  localparam int TICKS_PER_MS   = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam longint WAIT_TOTAL = longint'(TICKS_PER_MS) * longint'(DELAY_MS);

  logic        sync_seen;
  logic [47:0] since_sync;
  logic        done_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_seen  <= 1'b0;
      since_sync <= '0;
      done_seen  <= 1'b0;
    end else begin
      if (sync_en && !sync_seen) begin
        sync_seen  <= 1'b1;
        since_sync <= '0;
      end else if (sync_seen && since_sync != '1) begin
        since_sync <= since_sync + 1'b1;
      end
      if (done) done_seen <= 1'b1;
    end
  end

  // R3: launch only after sync and the full settling window
  assert_launch_after_delay_R3: assert property (@(posedge clk) disable iff (rst)
    rd_start |-> (sync_seen && since_sync >= 48'(WAIT_TOTAL)));

  // R3: launch is a single-cycle pulse
  assert_launch_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);

  // R10: no second done strobe in a reset period
  assert_single_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !done_seen);

  // R10: result frozen after done
  assert_mode_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    done_seen |-> $stable(mode_out));

  // R9: a valid override at resolve decides the result
  assert_override_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (done && $past(ovr_valid)) |-> (mode_out == $past(ovr_mode)));

endmodule

bind mode_select_seq ms_seq_checker #(
  .CLK_HZ   (CLK_HZ),
  .DELAY_MS (DELAY_MS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_en   (sync_en),
  .rd_start  (rd_start),
  .done      (done),
  .mode_out  (mode_out),
  .ovr_valid (ovr_valid),
  .ovr_mode  (ovr_mode)
);

// File: tb/tb_mode_select_seq.sv
module tb_mode_select_seq;

  localparam int CLK_HZ   = 2000;
  localparam int DELAY_MS = 1500;
  localparam int TOTAL    = (CLK_HZ / 1000) * DELAY_MS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sense_code = '0;
  logic       sync_en = 1'b0;
  logic       rd_start;
  logic       rd_valid = 1'b0;
  logic [7:0] rd_data = '0;
  logic       rd_nodata = 1'b0;
  logic       ovr_valid = 1'b0;
  logic [3:0] ovr_mode = '0;
  logic [3:0] mode_out;
  logic       done;

  int         checks = 0;
  int         errors = 0;
  int         done_count = 0;
  logic [3:0] exp_q[$];
  logic [7:0] img[128];

  always #4 clk = ~clk;

  mode_select_seq #(
    .CLK_HZ   (CLK_HZ),
    .DELAY_MS (DELAY_MS),
    .SENSE_W  (3)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .sense_code (sense_code),
    .sync_en    (sync_en),
    .rd_start   (rd_start),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .rd_nodata  (rd_nodata),
    .ovr_valid  (ovr_valid),
    .ovr_mode   (ovr_mode),
    .mode_out   (mode_out),
    .done       (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: pop expected final mode on each done strobe
  always @(negedge clk) begin
    if (!rst && done) begin
      done_count++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected extra done", mode_out, -1);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(mode_out == e, "R6/R8/R9 final mode at done", mode_out, e);
      end
    end
  end

  task automatic clear_img();
    for (int i = 0; i < 128; i++) img[i] = 8'h00;
    for (int i = 38; i < 54; i++) img[i] = 8'h01;
  endtask

  task automatic set_ent(input int k, input logic [7:0] b0, input logic [7:0] b1);
    img[38 + 2 * k] = b0;
    img[39 + 2 * k] = b1;
  endtask

  task automatic run_case(input string tag, input logic [2:0] s, input bit nodata,
                          input bit gaps, input bit ov, input logic [3:0] om,
                          input logic [3:0] expv);
    int         base;
    int         n;
    bit         early;
    logic [3:0] held;
    logic [3:0] sense_exp;
    base = done_count;
    exp_q.push_back(expv);
    @(negedge clk);
    rst = 1'b1; sense_code = s; ovr_valid = ov; ovr_mode = om;
    sync_en = 1'b0; rd_valid = 1'b0; rd_nodata = 1'b0;
    repeat (3) @(negedge clk);
    chk(mode_out == 4'd4 && !done && !rd_start, {"R1 reset state ", tag}, mode_out, 4);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    sense_exp = (s == 3'd0) ? 4'd4 : {1'b0, s};
    chk(mode_out == sense_exp, {"R2 sense mode ", tag}, mode_out, sense_exp);
    early = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (rd_start) early = 1'b1;
    end
    chk(!early, {"R3 no launch before sync ", tag}, early, 0);
    sync_en = 1'b1;
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rd_start || n > TOTAL + 10) break;
    end
    chk(n >= TOTAL && n <= TOTAL + 2, {"R3 launch delay ", tag}, n, TOTAL + 1);
    if (nodata) begin
      rd_nodata = 1'b1;
      @(negedge clk);
      rd_nodata = 1'b0;
    end else begin
      for (int i = 0; i < 128; i++) begin
        rd_valid = 1'b1;
        rd_data  = img[i];
        @(negedge clk);
        if (gaps && (i % 3 == 0)) begin
          rd_valid = 1'b0;
          rd_data  = 8'h00;
          @(negedge clk);
        end
      end
      rd_valid = 1'b0;
    end
    repeat (5) @(negedge clk);
    chk(done_count == base + 1, {"R10 one done ", tag}, done_count - base, 1);
    // Later reader responses and override changes must not matter
    held = mode_out;
    rd_nodata = 1'b1;
    @(negedge clk);
    rd_nodata = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd_valid = 1'b1;
      rd_data  = (i % 2 == 0) ? 8'd49 : 8'h40;
      @(negedge clk);
    end
    rd_valid  = 1'b0;
    ovr_valid = ~ov;
    ovr_mode  = ~om;
    repeat (10) @(negedge clk);
    chk(mode_out == held && done_count == base + 1,
        {"R10 later responses ignored ", tag}, mode_out, held);
    ovr_valid = ov;
    ovr_mode  = om;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8, R2: no sense code, no image -> default mode 4
    clear_img();
    run_case("A", 3'd0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd4);

    // R6, R7: unused pair and unsupported entry skipped, earliest match wins
    clear_img();
    set_ent(0, 8'h01, 8'h01);
    set_ent(1, 8'd113, 8'h4F);
    set_ent(2, 8'd97,  8'h4F);
    set_ent(3, 8'd69,  8'h4F);
    run_case("B", 3'd6, 1'b0, 1'b1, 1'b0, 4'd0, 4'd3);

    // R11, R8: supported patterns only outside window, none inside match
    clear_img();
    img[36] = 8'd129; img[37] = 8'h80;
    img[54] = 8'd129; img[55] = 8'h80;
    set_ent(0, 8'd49, 8'h80);
    set_ent(1, 8'd129, 8'h40);
    run_case("C", 3'd2, 1'b0, 1'b0, 1'b0, 4'd0, 4'd2);

    // R9: override beats a supported entry
    clear_img();
    set_ent(0, 8'd113, 8'h46);
    run_case("D", 3'd1, 1'b0, 1'b0, 1'b1, 4'd7, 4'd7);

    // R4, R7: only the last slot holds an entry
    clear_img();
    set_ent(7, 8'd129, 8'h80);
    run_case("E", 3'd5, 1'b0, 1'b1, 1'b0, 4'd0, 4'd6);

    // R5: mode 0 reached through the image only
    clear_img();
    set_ent(0, 8'd49, 8'h40);
    run_case("F", 3'd7, 1'b0, 1'b0, 1'b0, 4'd0, 4'd0);

    // R9: override with no image available
    clear_img();
    run_case("G", 3'd3, 1'b1, 1'b0, 1'b1, 4'd2, 4'd2);

    chk(exp_q.size() == 0, "R10 missing done", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule